// File: doc/BRIEF.md
# Single-Frame Network Mailbox

The block connects software to a byte-stream network path using one receive frame buffer and one transmit frame buffer, each 1514 bytes deep. Software drains a received frame through a receive data port, one byte per read. It builds an outgoing frame by first programming a length and then writing bytes, one per write, into a transmit data port. Register accesses are full 32-bit words. Only the low six address bits select a register, so the map repeats every 64 bytes.

Incoming frames arrive as a byte stream with valid, last and ready. The block takes a new frame only when it is not busy and the held frame is not full. Once the final transmit byte is written, the finished frame leaves on an outgoing byte stream with valid, last and a downstream ready. A single level interrupt is high while any cause bit is pending. Busy is set when a frame is received or sent. Each write to the interrupt-control register recomputes busy from the remaining cause bits.

Top module: `frame_mailbox`

## Requirements
- R1: Register offsets are taken from address bits [5:0] only. 0x00 reads 0x4D495053 and 0x04 reads 0x4E455430. 0x18 (interrupt info) and 0x20 (transmit data port) always read 0.
- R2: After reset, busy (0x08, bit 0) reads 1, and the receive count (0x0C), transmit count (0x10) and interrupt control (0x14) read 0. The interrupt output is low.
- R3: Interrupt control holds transmit-done at bit 0, receive-done at bit 1 and self-test at bit 31. The interrupt output is high exactly when one of them is set, and busy is then 1.
- R4: A read of 0x14 returns the current value, and self-test (bit 31) is clear from the next cycle on.
- R5: A write to 0x14 clears transmit-done if wdata bit 0 is set. Otherwise it clears receive-done if bit 1 is set. A write of zero changes no cause bit. After any such write, busy equals the OR of the remaining cause bits.
- R6: A write to 0x14 with bits 0 and 1 clear and bit 31 set zeroes both counts and both pointers. It leaves only self-test set, so busy is 1.
- R7: rx_ready is high at the start of a frame only when busy is 0 and the receive count is below 1514. Once the first byte of a frame is taken, rx_ready stays high until its last byte.
- R8: A taken frame is stored from index 0. At its last byte, the receive count becomes the frame length and the read pointer becomes 0, with the count saturating at 1514 and extra bytes dropped. Receive-done and busy are set.
- R9: A read of 0x1C with a nonzero count returns the byte at the read pointer, decrements the count and advances the pointer. With a zero count it returns 0 and changes nothing.
- R10: A write to 0x10 stores wdata when it is at most 1514 and stores 0 otherwise. It also rewinds the transmit write pointer.
- R11: A write to 0x20 stores wdata[7:0] and advances the pointer. When the pointer reaches the count, the frame is launched, the count and pointer return to 0, and transmit-done and busy are set.
- R12: The launched frame appears on tx_byte in index order, with tx_last on the final byte. While tx_ready is low, the current byte is held.
- R13: Writes to 0x00, 0x08, 0x0C, 0x18 and 0x1C have no effect. Writes to 0x20 are also discarded while the transmit count is 0 or while a frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address; bits [5:0] decoded |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, ignored when bus_wr is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt, any cause pending |
| rx_valid | input | 1 | Incoming byte valid |
| rx_byte | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block takes the incoming byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Downstream takes the outgoing byte |

## Verification
Frame completion on the receive side can land in the same clock edge as a software write to interrupt control. The write clears transmit-done and recomputes busy, while the last byte sets receive-done and forces busy. The bench sets this up as follows. It starts a receive frame while idle and sends a transmit frame so that transmit-done is pending. It then presents the final receive byte in the very cycle it writes 0x1 to interrupt control. It judges the result by reading interrupt control back as 0x2 with busy 1, and by checking that the stored frame length and bytes are intact.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
  localparam logic [5:0] OFF_ID_HI  = 6'h00;
  localparam logic [5:0] OFF_ID_LO  = 6'h04;
  localparam logic [5:0] OFF_BUSY   = 6'h08;
  localparam logic [5:0] OFF_RXLEN  = 6'h0C;
  localparam logic [5:0] OFF_TXLEN  = 6'h10;
  localparam logic [5:0] OFF_CAUSE  = 6'h14;
  localparam logic [5:0] OFF_INFO   = 6'h18;
  localparam logic [5:0] OFF_RXPORT = 6'h1C;
  localparam logic [5:0] OFF_TXPORT = 6'h20;

  localparam logic [31:0] ID_WORD_HI = 32'h4D49_5053;
  localparam logic [31:0] ID_WORD_LO = 32'h4E45_5430;

  localparam int CB_TX   = 0;
  localparam int CB_RX   = 1;
  localparam int CB_TEST = 31;

  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } cause_t;
endpackage

// File: rtl/fmb_byte_ram.sv
module fmb_byte_ram #(
  parameter int DEPTH = 1514,
  parameter int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wbyte,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rbyte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (widx < IDX_W'(DEPTH))) mem[widx] <= wbyte;
  end

  assign rbyte = (ridx < IDX_W'(DEPTH)) ? mem[ridx] : 8'h00;
endmodule

// File: rtl/fmb_rx_ingest.sv
module fmb_rx_ingest #(
  parameter int DEPTH = 1514,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             beat_last,
  output logic             active,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic             done,
  output logic [CNT_W-1:0] len
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             room;

  assign room   = idx_q < CNT_W'(DEPTH);
  assign active = act_q;
  assign wr_en  = beat && room;
  assign wr_idx = idx_q;
  assign done   = beat && beat_last;
  assign len    = room ? idx_q + CNT_W'(1) : CNT_W'(DEPTH);

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (beat) begin
      if (beat_last) begin
        act_d = 1'b0;
        idx_d = '0;
      end else begin
        act_d = 1'b1;
        if (room) idx_d = idx_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  p_idle_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && beat_last) |=> !active);
  p_len_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len != '0) && (len <= CNT_W'(DEPTH)));
endmodule

// File: rtl/fmb_tx_emit.sv
module fmb_tx_emit #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_len,
  input  logic             out_ready,
  output logic             on,
  output logic [CNT_W-1:0] ridx,
  output logic             last
);
  logic             on_q, on_d;
  logic [CNT_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] len_q, len_d;

  assign on   = on_q;
  assign ridx = ptr_q;
  assign last = on_q && (ptr_q == len_q - CNT_W'(1));

  always_comb begin
    on_d  = on_q;
    ptr_d = ptr_q;
    len_d = len_q;
    if (start) begin
      on_d  = 1'b1;
      ptr_d = '0;
      len_d = start_len;
    end else if (on_q && out_ready) begin
      if (last) on_d = 1'b0;
      else      ptr_d = ptr_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      ptr_q <= '0;
      len_q <= '0;
    end else begin
      on_q  <= on_d;
      ptr_q <= ptr_d;
      len_q <= len_d;
    end
  end

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !out_ready) |=> (on && $stable(ptr_q)));
  p_no_relaunch_r13: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !on_q);
endmodule

// File: rtl/frame_mailbox.sv
module frame_mailbox
  import fmb_pkg::*;
#(
  parameter int DEPTH  = 1514,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_last,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             busy_q, busy_d;
  cause_t           cause_q, cause_d;
  logic [CNT_W-1:0] rx_cnt_q, rx_cnt_d, rx_ptr_q, rx_ptr_d;
  logic [CNT_W-1:0] tx_cnt_q, tx_cnt_d, tx_wptr_q, tx_wptr_d;

  logic [5:0]       off;
  logic             rd_act, unused_hi;
  logic             rx_act, rx_we, rx_fin;
  logic [CNT_W-1:0] rx_widx, rx_len;
  logic [7:0]       rx_rbyte;
  logic             tx_on, tx_store, tx_fin;
  logic [CNT_W-1:0] tx_ridx;

  assign off       = bus_addr[5:0];
  assign unused_hi = ^bus_addr[ADDR_W-1:6];
  assign rd_act    = bus_rd && !bus_wr;
  assign irq       = |cause_q;
  assign rx_ready  = rx_act || (!busy_q && (rx_cnt_q < FULL));

  fmb_rx_ingest #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ingest (
    .clk(clk), .rst_n(rst_n), .beat(rx_valid && rx_ready), .beat_last(rx_last),
    .active(rx_act), .wr_en(rx_we), .wr_idx(rx_widx), .done(rx_fin), .len(rx_len)
  );

  fmb_byte_ram #(.DEPTH(DEPTH), .IDX_W(CNT_W)) u_rx_ram (
    .clk(clk), .we(rx_we), .widx(rx_widx), .wbyte(rx_byte),
    .ridx(rx_ptr_q), .rbyte(rx_rbyte)
  );

  assign tx_store = bus_wr && (off == OFF_TXPORT) && !tx_on &&
                    (tx_cnt_q != '0) && (tx_wptr_q < FULL);
  assign tx_fin   = tx_store && ((tx_wptr_q + CNT_W'(1)) == tx_cnt_q);

  fmb_byte_ram #(.DEPTH(DEPTH), .IDX_W(CNT_W)) u_tx_ram (
    .clk(clk), .we(tx_store), .widx(tx_wptr_q), .wbyte(bus_wdata[7:0]),
    .ridx(tx_ridx), .rbyte(tx_byte)
  );

  fmb_tx_emit #(.CNT_W(CNT_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(tx_fin), .start_len(tx_cnt_q),
    .out_ready(tx_ready), .on(tx_on), .ridx(tx_ridx), .last(tx_last)
  );
  assign tx_valid = tx_on;

  always_comb begin
    bus_rdata = '0;
    if (rd_act) begin
      case (off)
        OFF_ID_HI:  bus_rdata = ID_WORD_HI;
        OFF_ID_LO:  bus_rdata = ID_WORD_LO;
        OFF_BUSY:   bus_rdata = 32'(busy_q);
        OFF_RXLEN:  bus_rdata = 32'(rx_cnt_q);
        OFF_TXLEN:  bus_rdata = 32'(tx_cnt_q);
        OFF_CAUSE:  bus_rdata = {cause_q.test, 29'b0, cause_q.rx_done, cause_q.tx_done};
        OFF_RXPORT: bus_rdata = (rx_cnt_q != '0) ? 32'(rx_rbyte) : 32'h0;
        default:    bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    busy_d    = busy_q;
    cause_d   = cause_q;
    rx_cnt_d  = rx_cnt_q;
    rx_ptr_d  = rx_ptr_q;
    tx_cnt_d  = tx_cnt_q;
    tx_wptr_d = tx_wptr_q;
    if (bus_wr) begin
      case (off)
        OFF_TXLEN: begin
          tx_cnt_d  = (bus_wdata <= 32'(DEPTH)) ? bus_wdata[CNT_W-1:0] : '0;
          tx_wptr_d = '0;
        end
        OFF_CAUSE: begin
          if (bus_wdata[CB_TX]) begin
            cause_d.tx_done = 1'b0;
          end else if (bus_wdata[CB_RX]) begin
            cause_d.rx_done = 1'b0;
          end else if (bus_wdata[CB_TEST]) begin
            rx_cnt_d  = '0;
            rx_ptr_d  = '0;
            tx_cnt_d  = '0;
            tx_wptr_d = '0;
            cause_d   = '{test: 1'b1, rx_done: 1'b0, tx_done: 1'b0};
          end
          busy_d = |cause_d;
        end
        OFF_TXPORT: begin
          if (tx_fin) begin
            tx_cnt_d        = '0;
            tx_wptr_d       = '0;
            cause_d.tx_done = 1'b1;
            busy_d          = 1'b1;
          end else if (tx_store) begin
            tx_wptr_d = tx_wptr_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end else if (bus_rd) begin
      if (off == OFF_CAUSE) cause_d.test = 1'b0;
      if ((off == OFF_RXPORT) && (rx_cnt_q != '0)) begin
        rx_cnt_d = rx_cnt_q - CNT_W'(1);
        rx_ptr_d = rx_ptr_q + CNT_W'(1);
      end
    end
    if (rx_fin) begin
      rx_cnt_d        = rx_len;
      rx_ptr_d        = '0;
      cause_d.rx_done = 1'b1;
      busy_d          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b1;
      cause_q   <= '0;
      rx_cnt_q  <= '0;
      rx_ptr_q  <= '0;
      tx_cnt_q  <= '0;
      tx_wptr_q <= '0;
    end else begin
      busy_q    <= busy_d;
      cause_q   <= cause_d;
      rx_cnt_q  <= rx_cnt_d;
      rx_ptr_q  <= rx_ptr_d;
      tx_cnt_q  <= tx_cnt_d;
      tx_wptr_q <= tx_wptr_d;
    end
  end

  p_irq_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy_q);
  p_test_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && (off == OFF_CAUSE)) |=> !cause_q.test);
  p_rx_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fin |=> (busy_q && cause_q.rx_done && (rx_ptr_q == '0)));
  p_rx_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rx_cnt_q} + {1'b0, rx_ptr_q}) <= {1'b0, FULL});
  p_tx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt_q <= FULL);
  p_tx_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fin |=> (cause_q.tx_done && busy_q && (tx_cnt_q == '0) && tx_valid));
endmodule

// File: tb/test_frame_mailbox.sv
`timescale 1ns/1ps
module test_frame_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  frame_mailbox i_frame_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send_beat(input logic [7:0] b, input logic l);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_last = l;
    #1;
    while (!rx_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) send_beat(8'(base + 8'(i)), i == n - 1);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // {wr, req, addr, wdata, expected}
  localparam int NV = 24;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 4'd1,  8'h00, 32'h0, 32'h4D495053},  // R1
    {1'b0, 4'd1,  8'h04, 32'h0, 32'h4E455430},  // R1
    {1'b0, 4'd1,  8'h44, 32'h0, 32'h4E455430},  // R1 alias
    {1'b0, 4'd1,  8'h18, 32'h0, 32'h0},         // R1
    {1'b0, 4'd1,  8'h20, 32'h0, 32'h0},         // R1
    {1'b0, 4'd2,  8'h08, 32'h0, 32'h1},         // R2
    {1'b0, 4'd2,  8'h0C, 32'h0, 32'h0},         // R2
    {1'b0, 4'd2,  8'h10, 32'h0, 32'h0},         // R2
    {1'b0, 4'd2,  8'h14, 32'h0, 32'h0},         // R2
    {1'b1, 4'd13, 8'h08, 32'h0, 32'h0},         // R13
    {1'b0, 4'd13, 8'h08, 32'h0, 32'h1},         // R13
    {1'b1, 4'd13, 8'h0C, 32'h5, 32'h0},         // R13
    {1'b0, 4'd13, 8'h0C, 32'h0, 32'h0},         // R13
    {1'b1, 4'd13, 8'h1C, 32'h7, 32'h0},         // R13
    {1'b0, 4'd13, 8'h0C, 32'h0, 32'h0},         // R13
    {1'b1, 4'd10, 8'h10, 32'd2000, 32'h0},      // R10
    {1'b0, 4'd10, 8'h10, 32'h0, 32'h0},         // R10
    {1'b1, 4'd10, 8'h10, 32'd1514, 32'h0},      // R10
    {1'b0, 4'd10, 8'h10, 32'h0, 32'd1514},      // R10
    {1'b1, 4'd10, 8'h10, 32'd1515, 32'h0},      // R10
    {1'b0, 4'd10, 8'h10, 32'h0, 32'h0},         // R10
    {1'b1, 4'd10, 8'h50, 32'd5, 32'h0},         // R10 alias of 0x10
    {1'b0, 4'd10, 8'h10, 32'h0, 32'd5},         // R10
    {1'b1, 4'd10, 8'h10, 32'h0, 32'h0}          // R10
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    chk("R2 irq low", 32'(irq), 32'h0);
    chk("R7 ready low while busy", 32'(rx_ready), 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [76:0] e;
      e = VEC[k];
      if (e[76]) wr(e[71:64], e[63:32]);
      else begin
        rd(e[71:64], v);
        chk($sformatf("R%0d vector %0d", e[75:72], k), v, e[31:0]);
      end
    end

    // R13: data-port write with zero count is discarded
    wr(8'h20, 32'h42);
    chk("R13 no launch on zero count", 32'(tx_valid), 32'h0);
    rd(8'h14, v); chk("R13 no tx done on zero count", v, 32'h0);

    // R5 write zero releases busy, R7 gate opens
    wr(8'h14, 32'h0);
    rd(8'h08, v); chk("R5 busy cleared by zero write", v, 32'h0);
    chk("R7 ready when idle", 32'(rx_ready), 32'h1);

    // R8 receive small frame
    send_frame(4, 8'hA0);
    rd(8'h0C, v); chk("R8 rx length", v, 32'd4);
    rd(8'h08, v); chk("R8 busy after frame", v, 32'h1);
    rd(8'h14, v); chk("R8 rx done set", v, 32'h2);
    chk("R3 irq with rx done", 32'(irq), 32'h1);
    chk("R7 ready low after frame", 32'(rx_ready), 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h1C, v); chk("R9 rx byte", v, 32'(8'hA0 + 8'(i)));
    end
    rd(8'h1C, v); chk("R9 empty port reads 0", v, 32'h0);
    rd(8'h0C, v); chk("R9 count drained", v, 32'h0);

    // R11/R12 transmit
    wr(8'h10, 32'd3);
    wr(8'h20, 32'h111);
    wr(8'h20, 32'h22);
    chk("R11 no launch before count", 32'(tx_valid), 32'h0);
    wr(8'h20, 32'h33);
    chk("R11 launched", 32'(tx_valid), 32'h1);
    chk("R12 first byte low bits", 32'(tx_byte), 32'h11);
    rd(8'h10, v); chk("R11 count back to 0", v, 32'h0);
    rd(8'h14, v); chk("R3 both causes", v, 32'h3);
    repeat (3) @(negedge clk);
    chk("R12 held while stalled", {23'b0, tx_valid, tx_byte}, {23'b0, 1'b1, 8'h11});
    wr(8'h10, 32'd2);
    wr(8'h20, 32'h99);   // R13 ignored while sending
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R12 stream byte", {22'b0, tx_valid, tx_last, tx_byte},
          {22'b0, 1'b1, i == 2, 8'(8'h11 * (i + 1))});
      @(negedge clk);
    end
    chk("R12 stream ends", 32'(tx_valid), 32'h0);
    wr(8'h20, 32'h55);
    chk("R13 write during send was dropped", 32'(tx_valid), 32'h0);
    wr(8'h20, 32'h66);
    chk("R11 second frame", {23'b0, tx_valid, tx_byte}, {23'b0, 1'b1, 8'h55});
    @(negedge clk);
    chk("R12 second last", {23'b0, tx_last, tx_byte}, {23'b0, 1'b1, 8'h66});
    @(negedge clk);
    tx_ready = 1'b0;

    // R5 one cause per write, in priority order
    wr(8'h14, 32'h3);
    rd(8'h14, v); chk("R5 only tx cleared", v, 32'h2);
    rd(8'h08, v); chk("R5 busy kept", v, 32'h1);
    wr(8'h14, 32'h8000_0002);
    rd(8'h14, v); chk("R5 rx cleared before test", v, 32'h0);
    rd(8'h08, v); chk("R5 busy dropped", v, 32'h0);
    chk("R3 irq low", 32'(irq), 32'h0);

    // R6 / R4 self test
    wr(8'h10, 32'd7);
    wr(8'h14, 32'h8000_0000);
    chk("R6 irq on test", 32'(irq), 32'h1);
    rd(8'h10, v); chk("R6 tx count cleared", v, 32'h0);
    rd(8'h08, v); chk("R6 busy set", v, 32'h1);
    rd(8'h14, v); chk("R4 test visible", v, 32'h8000_0000);
    chk("R4 irq after read", 32'(irq), 32'h0);
    rd(8'h14, v); chk("R4 test cleared", v, 32'h0);
    rd(8'h08, v); chk("R5 busy held until write", v, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h08, v); chk("R5 ack write", v, 32'h0);

    // R8 truncation, R7 full gate
    send_frame(1520, 8'h00);
    rd(8'h0C, v); chk("R8 saturated length", v, 32'd1514);
    wr(8'h14, 32'h2);
    rd(8'h08, v); chk("R5 idle after clear", v, 32'h0);
    chk("R7 full buffer blocks", 32'(rx_ready), 32'h0);
    rd(8'h1C, v); chk("R9 first byte", v, 32'h00);
    rd(8'h1C, v); chk("R9 second byte", v, 32'h01);
    chk("R7 opens below full", 32'(rx_ready), 32'h1);
    rd(8'h0C, v); chk("R9 count", v, 32'd1512);

    // concurrency: rx end with cause write
    send_beat(8'hC0, 1'b0);
    send_beat(8'hC1, 1'b0);
    @(negedge clk);
    rx_valid = 1'b0;
    wr(8'h10, 32'd1);
    wr(8'h20, 32'h77);
    chk("R11 single byte launch", {22'b0, tx_valid, tx_last, tx_byte}, {22'b0, 1'b1, 1'b1, 8'h77});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R7 mid-frame ready while busy", 32'(rx_ready), 32'h1);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'hC2; rx_last = 1'b1;
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; bus_wr = 1'b0;
    rd(8'h14, v); chk("R5 R8 same-edge causes", v, 32'h2);
    rd(8'h08, v); chk("R8 busy wins", v, 32'h1);
    rd(8'h0C, v); chk("R8 length", v, 32'd3);
    for (int i = 0; i < 3; i++) begin
      rd(8'h1C, v); chk("R9 concurrent bytes", v, 32'(8'hC0 + 8'(i)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule